// File: doc/BRIEF.md
# Pointer-Based Stuck-Cell Row Corrector

This block sits on the read path of a memory whose cells can fail permanently and stick at one value. Each stored row comes back with a small set of repair entries written alongside it. An entry names one data cell by its bit address and carries a spare bit that holds the value that cell should have. The block overlays each in-use spare bit onto the raw row and returns the repaired row, registered, one clock later.

The entries are filled in order, so entry 0 is used first. When two in-use entries name the same cell, the entry with the higher index decides the result. This lets a later entry fix a cell that an earlier entry already covers, and it also covers the case where that earlier entry's own spare bit has failed. A count that travels with the row says how many entries are in use. The block also reports, with the repaired row, whether every entry of that row is taken. A wider policy can use that flag to retire the row.

Top module: `ptr_row_repair`

## Requirements
- R1: When `valid_in` is high at a rising clock edge, `valid_out` is high after that edge and `row_out` holds the repaired row for the inputs sampled at that edge. When `valid_in` is low at an edge, `valid_out` is low after it.
- R2: While `rst_n` is low, and directly after it is released, `valid_out`, `full_out` and all bits of `row_out` are 0.
- R3: An in-use entry i forces `row_out[p]` to `ent_bit[i]`, where p is `ent_ptr[i*9 +: 9]` read as an unsigned cell address from 0 to 511.
- R4: Entry i is in use only when `ent_on[i]` is 1 and i is less than `ent_cnt`. An entry at or above the count has no effect on `row_out`, even when its flag is set.
- R5: An entry whose `ent_on` bit is 0 has no effect on `row_out`, even when its index is below the count.
- R6: When several in-use entries name the same cell, `row_out` at that cell takes the replacement bit of the highest-numbered of them.
- R7: Every cell that no in-use entry names passes from `raw_row` to `row_out` unchanged.
- R8: `full_out` is updated with `row_out`. It is 1 exactly when the sampled `ent_cnt` is 6 or more. A count of 7 is treated as 6 entries in use.
- R9: After an edge with `valid_in` low, `row_out` and `full_out` keep the values they had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Row and entries are present this cycle |
| raw_row | input | 512 | Row as read from the cells |
| ent_ptr | input | 54 | Six 9-bit cell addresses; entry i in bits [i*9 +: 9] |
| ent_bit | input | 6 | Replacement bit of each entry |
| ent_on | input | 6 | Per-entry in-use flag |
| ent_cnt | input | 3 | Number of entries in use (0 to 6) |
| valid_out | output | 1 | Repaired row is present |
| row_out | output | 512 | Repaired row |
| full_out | output | 1 | All entries of the row are in use |

## Verification
A fault in the entry-gating or precedence logic shows up as a wrong bit in `row_out` in the cycle right after the sampled request. For that reason every check compares the whole 512-bit row against a model built from the requirements, not only the addressed cells. Duplicate addresses, gating by the flag and by the count, and a count of 7 each get their own scenario, because an error in any of them can change a single cell while every other bit stays correct. A capture register that loads when it should not would show as a change to `row_out` during idle cycles, and the hold scenario looks for exactly that.

// File: rtl/ptr_row_repair.sv
module ptr_row_repair #(
  parameter int ROW_BITS = 512,
  parameter int N_ENT    = 6,
  localparam int PTR_W   = $clog2(ROW_BITS),
  localparam int CNT_W   = $clog2(N_ENT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_in,
  input  logic [ROW_BITS-1:0]     raw_row,
  input  logic [N_ENT*PTR_W-1:0]  ent_ptr,
  input  logic [N_ENT-1:0]        ent_bit,
  input  logic [N_ENT-1:0]        ent_on,
  input  logic [CNT_W-1:0]        ent_cnt,
  output logic                    valid_out,
  output logic [ROW_BITS-1:0]     row_out,
  output logic                    full_out
);

  localparam logic [PTR_W:0]   ROW_LIM = (PTR_W+1)'(ROW_BITS);
  localparam logic [CNT_W-1:0] N_CNT   = CNT_W'(N_ENT);

  logic [N_ENT-1:0]    live;
  logic [ROW_BITS-1:0] fixed;

  for (genvar i = 0; i < N_ENT; i++) begin : g_live
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    assign live[i] = ent_on[i] && (IDX < ent_cnt)
                     && ({1'b0, ent_ptr[i*PTR_W +: PTR_W]} < ROW_LIM);
  end

  always_comb begin
    fixed = raw_row;
    for (int i = 0; i < N_ENT; i++)
      if (live[i]) fixed[ent_ptr[i*PTR_W +: PTR_W]] = ent_bit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      row_out   <= '0;
      full_out  <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        row_out  <= fixed;
        full_out <= (ent_cnt >= N_CNT);
      end
    end
  end

  logic [PTR_W-1:0] top_ptr;
  assign top_ptr = ent_ptr[(N_ENT-1)*PTR_W +: PTR_W];

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  a_r9_hold_row: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(row_out) && $stable(full_out)));
  a_r7_no_entries_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ent_on == '0) |=> row_out == $past(raw_row));
  a_r6_top_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && ent_on[N_ENT-1] && ent_cnt >= N_CNT)
      |=> row_out[$past(top_ptr)] == $past(ent_bit[N_ENT-1]));
  a_r8_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> full_out == ($past(ent_cnt) >= N_CNT));

endmodule

// File: tb/test_ptr_row_repair.sv
`timescale 1ns/1ps
module test_ptr_row_repair;
  localparam int RB = 512, NE = 6, PW = 9, CW = 3;

  logic clk = 0, rst_n = 0, valid_in = 0;
  logic [RB-1:0] raw_row = '0;
  logic [NE*PW-1:0] ent_ptr = '0;
  logic [NE-1:0] ent_bit = '0, ent_on = '0;
  logic [CW-1:0] ent_cnt = '0;
  logic valid_out, full_out;
  logic [RB-1:0] row_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptr_row_repair i_ptr_row_repair (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .raw_row(raw_row),
    .ent_ptr(ent_ptr), .ent_bit(ent_bit), .ent_on(ent_on), .ent_cnt(ent_cnt),
    .valid_out(valid_out), .row_out(row_out), .full_out(full_out));

  function automatic logic [RB-1:0] model(input logic [RB-1:0] r,
      input logic [NE*PW-1:0] p, input logic [NE-1:0] b,
      input logic [NE-1:0] on, input logic [CW-1:0] c);
    logic [RB-1:0] m = r;
    for (int i = 0; i < NE; i++)
      if (on[i] && i < int'(c)) m[p[i*PW +: PW]] = b[i];
    return m;
  endfunction

  task automatic chk(string req, logic [RB-1:0] act, logic [RB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RB-1:0] rnd_row();
    logic [RB-1:0] v;
    for (int k = 0; k < RB/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic set_ptr(int i, int p);
    ent_ptr[i*PW +: PW] = PW'(p);
  endtask

  task automatic run_one(string req);
    logic [RB-1:0] exp;
    logic expf;
    @(negedge clk);
    valid_in = 1;
    exp  = model(raw_row, ent_ptr, ent_bit, ent_on, ent_cnt);
    expf = (ent_cnt >= 3'd6);
    @(negedge clk);
    valid_in = 0;
    chk({req, " valid"}, RB'(valid_out), RB'(1'b1));
    chk(req, row_out, exp);
    chk({req, " full"}, RB'(full_out), RB'(expf));
  endtask

  task automatic t_reset();
    chk("R2 valid", RB'(valid_out), '0);
    chk("R2 row", row_out, '0);
    chk("R2 full", RB'(full_out), '0);
  endtask

  task automatic t_passthru();
    raw_row = rnd_row(); ent_on = '0; ent_cnt = 3'd6; ent_bit = '1;
    run_one("R7 no entries");
  endtask

  task automatic t_single();
    raw_row = '0; ent_on = 6'b000001; ent_cnt = 3'd1; ent_bit = 6'b000001;
    set_ptr(0, 511);
    run_one("R3 single top cell");
    raw_row = '1; ent_bit = '0; set_ptr(0, 0);
    run_one("R3 single cell 0");
    chk("R3 cell0", RB'(row_out[0]), '0);
  endtask

  task automatic t_dup();
    raw_row = rnd_row(); ent_on = '1; ent_cnt = 3'd6;
    for (int i = 0; i < NE; i++) set_ptr(i, 77);
    ent_bit = 6'b011111;
    run_one("R6 dup all six");
    chk("R6 cell77", RB'(row_out[77]), '0);
    set_ptr(5, 3); ent_bit = 6'b010000;
    run_one("R6 dup five");
    chk("R6 cell77 e4", RB'(row_out[77]), RB'(1'b1));
  endtask

  task automatic t_cnt_gate();
    raw_row = '0; ent_on = '1; ent_bit = '1; ent_cnt = 3'd2;
    for (int i = 0; i < NE; i++) set_ptr(i, 10 + i);
    run_one("R4 count gate");
    chk("R4 cell13", RB'(row_out[13:10]), RB'(4'b0011));
  endtask

  task automatic t_flag_gate();
    raw_row = '0; ent_bit = '1; ent_cnt = 3'd6; ent_on = 6'b101010;
    for (int i = 0; i < NE; i++) set_ptr(i, 200 + i);
    run_one("R5 flag gate");
    chk("R5 cells", RB'(row_out[205:200]), RB'(6'b101010));
  endtask

  task automatic t_full7();
    raw_row = rnd_row(); ent_on = '1; ent_bit = $urandom; ent_cnt = 3'd7;
    for (int i = 0; i < NE; i++) set_ptr(i, $urandom_range(0, 511));
    run_one("R8 count seven");
    ent_cnt = 3'd5;
    run_one("R8 count five");
  endtask

  task automatic t_hold();
    logic [RB-1:0] prev;
    logic pf;
    prev = row_out; pf = full_out;
    raw_row = ~raw_row; ent_cnt = 3'd0;
    repeat (3) @(negedge clk);
    chk("R9 hold row", row_out, prev);
    chk("R9 hold full", RB'(full_out), RB'(pf));
    chk("R1 idle valid", RB'(valid_out), '0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      raw_row = rnd_row(); ent_on = $urandom; ent_bit = $urandom;
      ent_cnt = CW'($urandom_range(0, 7));
      for (int i = 0; i < NE; i++) set_ptr(i, $urandom_range(0, 511));
      if (n % 4 == 0) set_ptr(NE-1, int'(ent_ptr[PW-1:0]));
      run_one("R1 random");
    end
  endtask

  task automatic t_back2back();
    logic [RB-1:0] e1, e2;
    @(negedge clk);
    raw_row = rnd_row(); ent_on = '1; ent_cnt = 3'd3; ent_bit = $urandom;
    set_ptr(0, 1); set_ptr(1, 2); set_ptr(2, 1);
    e1 = model(raw_row, ent_ptr, ent_bit, ent_on, ent_cnt);
    valid_in = 1;
    @(negedge clk);
    chk("R1 b2b first", row_out, e1);
    raw_row = rnd_row();
    e2 = model(raw_row, ent_ptr, ent_bit, ent_on, ent_cnt);
    @(negedge clk);
    valid_in = 0;
    chk("R1 b2b second", row_out, e2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_single();
    t_dup();
    t_cnt_gate();
    t_flag_gate();
    t_full7();
    t_hold();
    t_back2back();
    t_random();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule